// File: doc/BRIEF.md
# Host Register File with Sub-Addressing

This block is the register file that a microcontroller sees when it talks to a network controller over an 8-bit parallel bus. The host selects one of eight register addresses with a 3-bit address. It reads through a combinational read-data path. A single-cycle write strobe writes a register and a single-cycle read strobe marks a read that has side effects. Behind the bus sit a read-only status register, a diagnostic register whose event flags clear when the host reads them, a write-only command port, a two-byte RAM address pointer, a configuration register and a sub-address register. Register address 7 is a window whose meaning the sub-address picks.

The core feeds status loads, live status bits, diagnostic event pulses, a software reset and the next-ID byte into the block. It takes back command strobes, the committed RAM address, the configuration byte and the contents of the windowed setup and node-ID registers. The hardware reset is asynchronous and active low. Its release is synchronized inside the block, so internal state leaves reset on the second rising clock edge after the reset input goes high.

Register addresses: 0 reads status and writes command, 1 diagnostic, 2 pointer high, 3 pointer low, 4 unused (reads 0), 5 sub-address, 6 configuration, 7 windowed register.

Top module: `hreg_file`

## Requirements
- R1: After hardware reset, status reads 1, live[1:0], 1, 0001 (bit 7 = 1, bits 6:5 = live inputs, bits 4:0 = 10001), diagnostic reads 0000000 plus the live bit in bit 0, configuration reads 0x18, sub-address reads 0, and neither strobe output is high.
- R2: Status bits 6:5 always follow stat_live. Bits 7 and 4:0 take stat_in[5] and stat_in[4:0] on the edge where stat_load is high, and hold otherwise.
- R3: Diagnostic bits 7, 6, 5, 4 and 1 are set by diag_evt[6], [5], [4], [3] and [0]. A read strobe at address 1 clears them. An event in the same cycle as the clearing read leaves its bit set.
- R4: Diagnostic bit 3 (excess-NAK, set by diag_evt[2]) survives reads. It clears only on a command write of the clear-flags code (default 0x1E) or on a reset. An event in the same cycle as that command leaves it set.
- R5: Diagnostic bit 2 (new-next-ID, set by diag_evt[1]) survives reads and the clear-flags command. Only a hardware or software reset clears it.
- R6: A one-cycle sw_rst returns status bits 7, 4:0 and all stored diagnostic bits to their reset values. It leaves configuration, sub-address, pointer and windowed registers unchanged.
- R7: Writing address 2 stores the pointer high byte but does not change ram_addr. Writing address 3 sets ram_addr to {high[ADDR_W-9:0], written byte} and pulses ram_addr_stb for one cycle. Both bytes read back.
- R8: Each write to address 0 pulses cmd_stb for exactly the one cycle after the write, with cmd_byte equal to the written byte. No other access pulses it.
- R9: Sub-address bits 1:0 and configuration bits 1:0 are one value: writing either address changes what both read, and cfg_out[1:0].
- R10: Writing address 5 sets sub-address bit 2 from data bit 2. Any configuration write clears sub-address bit 2.
- R11: Address 7 maps by sub-address: 0 node-ID, 1 setup-1, 2 next-ID (read-only, from next_id_in), 4 setup-2, all other values read 0. Writes to next-ID and to unassigned values change nothing.
- R12: Writes to address 1 and address 4 change nothing. Address 4 reads 0, and diagnostic bit 0 always follows diag_live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset from the core |
| addr | input | 3 | Host register address |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rd_en | input | 1 | Host read strobe, marks a read with side effects |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from addr |
| stat_load | input | 1 | Load stored status bits from stat_in |
| stat_in | input | 6 | New status bits: [5] for bit 7, [4:0] for bits 4:0 |
| stat_live | input | 2 | Live status bits 6:5 |
| diag_evt | input | 7 | Diagnostic event pulses, [k] sets bit k+1 |
| diag_live | input | 1 | Live diagnostic bit 0 |
| next_id_in | input | 8 | Next-ID byte shown in the window |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Last command byte written |
| ram_addr | output | ADDR_W | Committed RAM address |
| ram_addr_stb | output | 1 | One-cycle pulse when ram_addr is committed |
| cfg_out | output | 8 | Configuration byte |
| node_id | output | 8 | Node-ID register |
| setup1 | output | 8 | Setup-1 register |
| setup2 | output | 8 | Setup-2 register |

## Verification
Two pairs of functions can land on one clock edge. A diagnostic event can meet a clearing read, and the excess-NAK event can meet the clear-flags command. The bench provokes each pair by raising the event pulse in the same cycle as the read strobe or the command write. A following side-effect-free view of address 1 must show the bit still set, and one more clearing read must then remove it. A second coupling, between the mirrored sub-address bits and the configuration register, is judged by sweeping every value through each of the two addresses and reading both back.

// File: rtl/hreg_pkg.sv
package hreg_pkg;
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_DIAG = 3'd1;
  localparam logic [2:0] A_PHI  = 3'd2;
  localparam logic [2:0] A_PLO  = 3'd3;
  localparam logic [2:0] A_RSV  = 3'd4;
  localparam logic [2:0] A_SUB  = 3'd5;
  localparam logic [2:0] A_CFG  = 3'd6;
  localparam logic [2:0] A_WIN  = 3'd7;

  localparam logic [2:0] S_NODE   = 3'd0;
  localparam logic [2:0] S_SETUP1 = 3'd1;
  localparam logic [2:0] S_NEXT   = 3'd2;
  localparam logic [2:0] S_SETUP2 = 3'd4;

  // stored diagnostic index k corresponds to register bit k+1
  localparam int DIAG_W      = 7;
  localparam int DIAG_EXCNAK = 2;
  localparam int DIAG_NEWNXT = 1;

  localparam logic [7:0] CFG_RST  = 8'h18;
  localparam logic [5:0] STAT_RST = 6'b1_10001;
endpackage

// File: rtl/hreg_rst_sync.sv
module hreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/hreg_diag.sv
module hreg_diag
  import hreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              rd_clr,
  input  logic              flag_clr,
  input  logic [DIAG_W-1:0] evt,
  output logic [DIAG_W-1:0] flags
);
  logic [DIAG_W-1:0] flags_d;
  logic [DIAG_W-1:0] flags_en;

  for (genvar k = 0; k < DIAG_W; k++) begin : g_bit
    logic clr;
    if (k == DIAG_EXCNAK) begin : g_exc
      assign clr = flag_clr;
    end else if (k == DIAG_NEWNXT) begin : g_nxt
      assign clr = 1'b0;
    end else begin : g_gen
      assign clr = rd_clr;
    end
    // reset beats an event; an event beats a clear
    assign flags_d[k]  = sw_rst ? 1'b0 : (evt[k] | (flags[k] & ~clr));
    assign flags_en[k] = sw_rst | evt[k] | clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      for (int k = 0; k < DIAG_W; k++) begin
        if (flags_en[k]) flags[k] <= flags_d[k];
      end
    end
  end
endmodule

// File: rtl/hreg_ptr.sv
module hreg_ptr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [7:0]        wdata,
  output logic [7:0]        hi_q,
  output logic [7:0]        lo_q,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_stb
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] ram_addr_d;

  assign ram_addr_d = {hi_q[HI_W-1:0], wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      ram_addr <= '0;
      ram_stb  <= 1'b0;
    end else begin
      ram_stb <= wr_lo;
      if (wr_hi) hi_q <= wdata;
      if (wr_lo) begin
        lo_q     <= wdata;
        ram_addr <= ram_addr_d;
      end
    end
  end
endmodule

// File: rtl/hreg_subcfg.sv
module hreg_subcfg
  import hreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_sub,
  input  logic       wr_cfg,
  input  logic       wr_win,
  input  logic [7:0] wdata,
  input  logic [7:0] next_id_in,
  output logic [7:0] cfg,
  output logic [2:0] sub_sel,
  output logic [7:0] node_id,
  output logic [7:0] setup1,
  output logic [7:0] setup2,
  output logic [7:0] win_rdata
);
  localparam int NWIN = 3;
  localparam logic [2:0] WIN_CODE [NWIN] = '{S_NODE, S_SETUP1, S_SETUP2};

  logic [5:0] cfg_hi_q, cfg_hi_d;
  logic [1:0] sub_lo_q, sub_lo_d;
  logic       sub2_q, sub2_d;
  logic       cfg_en, sub_en;
  logic [7:0] win_q [NWIN];

  assign cfg_en = wr_cfg;
  assign sub_en = wr_cfg | wr_sub;

  always_comb begin
    cfg_hi_d = cfg_hi_q;
    sub_lo_d = sub_lo_q;
    sub2_d   = sub2_q;
    if (wr_cfg) begin
      cfg_hi_d = wdata[7:2];
      sub_lo_d = wdata[1:0];
      sub2_d   = 1'b0;
    end else if (wr_sub) begin
      sub_lo_d = wdata[1:0];
      sub2_d   = wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_hi_q <= CFG_RST[7:2];
      sub_lo_q <= CFG_RST[1:0];
      sub2_q   <= 1'b0;
    end else begin
      if (cfg_en) cfg_hi_q <= cfg_hi_d;
      if (sub_en) begin
        sub_lo_q <= sub_lo_d;
        sub2_q   <= sub2_d;
      end
    end
  end

  assign cfg     = {cfg_hi_q, sub_lo_q};
  assign sub_sel = {sub2_q, sub_lo_q};

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    logic en;
    assign en = wr_win && (sub_sel == WIN_CODE[k]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  win_q[k] <= '0;
      else if (en) win_q[k] <= wdata;
    end
  end

  assign node_id = win_q[0];
  assign setup1  = win_q[1];
  assign setup2  = win_q[2];

  always_comb begin
    case (sub_sel)
      S_NODE:   win_rdata = win_q[0];
      S_SETUP1: win_rdata = win_q[1];
      S_NEXT:   win_rdata = next_id_in;
      S_SETUP2: win_rdata = win_q[2];
      default:  win_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/hreg_file.sv
module hreg_file
  import hreg_pkg::*;
#(
  parameter int         ADDR_W         = 11,
  parameter logic [7:0] CLR_FLAGS_CODE = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              stat_load,
  input  logic [5:0]        stat_in,
  input  logic [1:0]        stat_live,
  input  logic [DIAG_W-1:0] diag_evt,
  input  logic              diag_live,
  input  logic [7:0]        next_id_in,
  output logic              cmd_stb,
  output logic [7:0]        cmd_byte,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_addr_stb,
  output logic [7:0]        cfg_out,
  output logic [7:0]        node_id,
  output logic [7:0]        setup1,
  output logic [7:0]        setup2
);
  logic rst_sync_n;
  logic wr_cmd, wr_phi, wr_plo, wr_sub, wr_cfg, wr_win;
  logic rd_clr, flag_clr;
  logic [5:0] stat_q, stat_d;
  logic       stat_en;
  logic       cmd_stb_d;
  logic [DIAG_W-1:0] diag_flags;
  logic [7:0] ptr_hi, ptr_lo, win_rdata;
  logic [2:0] sub_sel;

  hreg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign wr_cmd   = wr_en && (addr == A_STAT);
  assign wr_phi   = wr_en && (addr == A_PHI);
  assign wr_plo   = wr_en && (addr == A_PLO);
  assign wr_sub   = wr_en && (addr == A_SUB);
  assign wr_cfg   = wr_en && (addr == A_CFG);
  assign wr_win   = wr_en && (addr == A_WIN);
  assign rd_clr   = rd_en && (addr == A_DIAG);
  assign flag_clr = wr_cmd && (wdata == CLR_FLAGS_CODE);

  // status: stored bits {7,4:0}
  always_comb begin
    stat_d  = stat_q;
    stat_en = sw_rst | stat_load;
    if (sw_rst)         stat_d = STAT_RST;
    else if (stat_load) stat_d = stat_in;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  stat_q <= STAT_RST;
    else if (stat_en) stat_q <= stat_d;
  end

  // command port
  assign cmd_stb_d = wr_cmd;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmd_stb  <= 1'b0;
      cmd_byte <= '0;
    end else begin
      cmd_stb <= cmd_stb_d;
      if (wr_cmd) cmd_byte <= wdata;
    end
  end

  hreg_diag u_diag (
    .clk(clk), .rst_n(rst_sync_n), .sw_rst(sw_rst), .rd_clr(rd_clr),
    .flag_clr(flag_clr), .evt(diag_evt), .flags(diag_flags)
  );

  hreg_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_sync_n), .wr_hi(wr_phi), .wr_lo(wr_plo),
    .wdata(wdata), .hi_q(ptr_hi), .lo_q(ptr_lo), .ram_addr(ram_addr),
    .ram_stb(ram_addr_stb)
  );

  hreg_subcfg u_subcfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_sub(wr_sub), .wr_cfg(wr_cfg),
    .wr_win(wr_win), .wdata(wdata), .next_id_in(next_id_in), .cfg(cfg_out),
    .sub_sel(sub_sel), .node_id(node_id), .setup1(setup1), .setup2(setup2),
    .win_rdata(win_rdata)
  );

  always_comb begin
    case (addr)
      A_STAT:  rdata = {stat_q[5], stat_live, stat_q[4:0]};
      A_DIAG:  rdata = {diag_flags, diag_live};
      A_PHI:   rdata = ptr_hi;
      A_PLO:   rdata = ptr_lo;
      A_RSV:   rdata = 8'h00;
      A_SUB:   rdata = {5'b0, sub_sel};
      A_CFG:   rdata = cfg_out;
      default: rdata = win_rdata;
    endcase
  end
endmodule

// File: rtl/hreg_file_chk.sv
module hreg_file_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              sw_rst,
  input logic [2:0]        addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic              cmd_stb,
  input logic [7:0]        cmd_byte,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_addr_stb,
  input logic              excnak,
  input logic              gen0,
  input logic              evt0,
  input logic              sub2,
  input logic [1:0]        cfg_lo
);
  p_cmd_strobe_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 3'd0) |=> (cmd_stb && cmd_byte == $past(wdata)));

  p_cmd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && addr == 3'd0) |=> !cmd_stb);

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en && addr == 3'd3) |=> ($stable(ram_addr) && !ram_addr_stb));

  p_ptr_load_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 3'd3) |=> (ram_addr_stb && ram_addr[7:0] == $past(wdata)));

  p_sub2_clear_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == 3'd6) |=> !sub2);

  p_mirror_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (addr == 3'd5 || addr == 3'd6)) |=> (cfg_lo == $past(wdata[1:0])));

  p_excnak_read_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && addr == 3'd1 && excnak && !sw_rst && !(wr_en && addr == 3'd0)) |=> excnak);

  p_evt_wins_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt0 && !sw_rst) |=> gen0);
endmodule

bind hreg_file hreg_file_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .sw_rst(sw_rst), .addr(addr),
  .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .cmd_stb(cmd_stb),
  .cmd_byte(cmd_byte), .ram_addr(ram_addr), .ram_addr_stb(ram_addr_stb),
  .excnak(diag_flags[2]), .gen0(diag_flags[0]), .evt0(diag_evt[0]),
  .sub2(sub_sel[2]), .cfg_lo(cfg_out[1:0])
);

// File: tb/hreg_file_bench.sv
module hreg_file_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n, sw_rst, wr_en, rd_en, stat_load, diag_live;
  logic [2:0] addr;
  logic [7:0] wdata, rdata, next_id_in, cmd_byte, cfg_out, node_id, setup1, setup2;
  logic [5:0] stat_in;
  logic [1:0] stat_live;
  logic [6:0] diag_evt;
  logic cmd_stb, ram_addr_stb;
  logic [AW-1:0] ram_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hreg_file #(.ADDR_W(AW)) u_hreg_file (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .stat_load(stat_load),
    .stat_in(stat_in), .stat_live(stat_live), .diag_evt(diag_evt),
    .diag_live(diag_live), .next_id_in(next_id_in), .cmd_stb(cmd_stb),
    .cmd_byte(cmd_byte), .ram_addr(ram_addr), .ram_addr_stb(ram_addr_stb),
    .cfg_out(cfg_out), .node_id(node_id), .setup1(setup1), .setup2(setup2)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic evt_pulse(input logic [6:0] m);
    @(negedge clk); diag_evt = m;
    @(negedge clk); diag_evt = '0;
  endtask

  function automatic logic [7:0] stat_exp(input logic [5:0] s, input logic [1:0] l);
    return {s[5], l, s[4:0]};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, hi_v, lo_v, exp_cfg, cfg_snap, s1_snap;
    logic [AW-1:0] ra_snap;
    rst_n = 1'b0; sw_rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0;
    wdata = '0; stat_load = 1'b0; stat_in = '0; stat_live = 2'b10;
    diag_evt = '0; diag_live = 1'b1; next_id_in = 8'hC3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values
    peek(3'd0, d); chk("R1 status", d, 8'hD1);
    peek(3'd1, d); chk("R1 diag", d, 8'h01);
    peek(3'd6, d); chk("R1 config", d, 8'h18);
    peek(3'd5, d); chk("R1 subaddr", d, 8'h00);
    chk("R1 strobes", {cmd_stb, ram_addr_stb}, 2'b00);
    exp_cfg = 8'h18;

    // R2 live bits and loads
    for (int l = 0; l < 4; l++) begin
      stat_live = l[1:0]; peek(3'd0, d);
      chk("R2 live", d, stat_exp(6'b110001, l[1:0]));
    end
    for (int v = 0; v < 64; v++) begin
      stat_live = v[1:0] ^ 2'b01;
      @(negedge clk); stat_in = v[5:0]; stat_load = 1'b1;
      @(negedge clk); stat_load = 1'b0; stat_in = ~v[5:0];
      peek(3'd0, d); chk("R2 load", d, stat_exp(v[5:0], v[1:0] ^ 2'b01));
    end

    // R8 command sweep
    for (int v = 0; v < 256; v++) begin
      bus_wr(3'd0, v[7:0]);
      chk("R8 stb", {7'd0, cmd_stb, cmd_byte}, {8'h01, v[7:0]});
      @(negedge clk);
      chk("R8 one cycle", cmd_stb, 1'b0);
    end

    // R7 pointer commit on low write
    for (int v = 0; v < 256; v++) begin
      hi_v = v[7:0]; lo_v = v[7:0] ^ 8'h5A;
      ra_snap = ram_addr;
      bus_wr(3'd2, hi_v);
      chk("R7 hi no commit", ram_addr, ra_snap);
      chk("R7 hi no stb", ram_addr_stb, 1'b0);
      bus_wr(3'd3, lo_v);
      chk("R7 commit", {4'd0, ram_addr_stb, ram_addr}, {5'h01, hi_v[2:0], lo_v});
      peek(3'd2, d); chk("R7 hi readback", d, hi_v);
      peek(3'd3, d); chk("R7 lo readback", d, lo_v);
    end

    // R9 R10 mirror and sub bit 2
    for (int v = 0; v < 8; v++) begin
      bus_wr(3'd5, v[7:0] | 8'hF8);
      exp_cfg = {exp_cfg[7:2], v[1:0]};
      peek(3'd5, d); chk("R10 sub write", d, {5'd0, v[2:0]});
      peek(3'd6, d); chk("R9 cfg mirror", d, exp_cfg);
      chk("R9 cfg_out", cfg_out, exp_cfg);
    end
    for (int w = 0; w < 256; w++) begin
      bus_wr(3'd5, 8'h04 | w[7:0]);
      bus_wr(3'd6, w[7:0]);
      exp_cfg = w[7:0];
      peek(3'd6, d); chk("R9 cfg write", d, exp_cfg);
      peek(3'd5, d); chk("R10 sub2 cleared", d, {6'd0, w[1:0]});
    end

    // R11 window decode
    for (int s = 0; s < 8; s++) begin
      bus_wr(3'd5, s[7:0]);
      bus_wr(3'd7, 8'h30 + s[7:0]);
    end
    for (int s = 0; s < 8; s++) begin
      bus_wr(3'd5, s[7:0]);
      peek(3'd7, d);
      case (s)
        0: chk("R11 node", d, 8'h30);
        1: chk("R11 setup1", d, 8'h31);
        2: chk("R11 next id", d, 8'hC3);
        4: chk("R11 setup2", d, 8'h34);
        default: chk("R11 unassigned", d, 8'h00);
      endcase
    end
    chk("R11 ports", {node_id, setup1, setup2}, 24'h303134);

    // R12 ignored writes, live bit
    bus_wr(3'd1, 8'hFE);
    peek(3'd1, d); chk("R12 diag write ignored", d, 8'h01);
    diag_live = 1'b0;
    peek(3'd1, d); chk("R12 live bit", d, 8'h00);
    bus_wr(3'd4, 8'hA5);
    peek(3'd4, d); chk("R12 addr4 reads 0", d, 8'h00);
    diag_live = 1'b1;

    // R3 general bits: set, clear on read, event wins
    foreach (d[k]) begin end
    for (int k = 0; k < 7; k++) begin
      if (k == 1 || k == 2) continue;
      evt_pulse(7'(1 << k));
      peek(3'd1, d); chk("R3 set", d, 8'h01 | 8'(2 << k));
      bus_rd(3'd1, d); chk("R3 read value", d, 8'h01 | 8'(2 << k));
      peek(3'd1, d); chk("R3 cleared", d, 8'h01);
      @(negedge clk); addr = 3'd1; rd_en = 1'b1; diag_evt = 7'(1 << k);
      @(negedge clk); rd_en = 1'b0; diag_evt = '0;
      peek(3'd1, d); chk("R3 event wins", d, 8'h01 | 8'(2 << k));
      bus_rd(3'd1, d);
      peek(3'd1, d); chk("R3 cleared after", d, 8'h01);
    end

    // R4 excess-NAK
    evt_pulse(7'h04);
    bus_rd(3'd1, d);
    peek(3'd1, d); chk("R4 survives read", d, 8'h09);
    bus_wr(3'd0, 8'h1F);
    peek(3'd1, d); chk("R4 other cmd", d, 8'h09);
    bus_wr(3'd0, 8'h1E);
    peek(3'd1, d); chk("R4 clear cmd", d, 8'h01);
    @(negedge clk); addr = 3'd0; wdata = 8'h1E; wr_en = 1'b1; diag_evt = 7'h04;
    @(negedge clk); wr_en = 1'b0; diag_evt = '0;
    peek(3'd1, d); chk("R4 event wins", d, 8'h09);
    bus_wr(3'd0, 8'h1E);
    peek(3'd1, d); chk("R4 cleared", d, 8'h01);

    // R5 new-next-ID
    evt_pulse(7'h02);
    bus_rd(3'd1, d);
    peek(3'd1, d); chk("R5 survives read", d, 8'h05);
    bus_wr(3'd0, 8'h1E);
    peek(3'd1, d); chk("R5 survives clear cmd", d, 8'h05);

    // R6 software reset
    bus_wr(3'd5, 8'h06);
    bus_wr(3'd2, 8'h05); bus_wr(3'd3, 8'h77);
    evt_pulse(7'h45);
    @(negedge clk); stat_in = 6'b001010; stat_load = 1'b1;
    @(negedge clk); stat_load = 1'b0;
    cfg_snap = cfg_out; s1_snap = setup1; ra_snap = ram_addr;
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
    stat_live = 2'b01;
    peek(3'd0, d); chk("R6 status", d, 8'hB1);
    peek(3'd1, d); chk("R6 diag and R5 reset", d, 8'h01);
    chk("R6 cfg kept", cfg_out, cfg_snap);
    peek(3'd5, d); chk("R6 sub kept", d, 8'h06);
    chk("R6 ptr kept", ram_addr, ra_snap);
    peek(3'd3, d); chk("R6 ptr lo kept", d, 8'h77);
    chk("R6 setup kept", setup1, s1_snap);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule